// File: doc/BRIEF.md
# Write-Through Direct-Mapped Word Cache

This block sits between a processor load/store port and a slower main-memory port. It keeps a direct-mapped store of 2048 single-word lines, 8 KB in all. Loads that fall inside the cacheable window are answered from the store when the line holds a matching tag. A missing word is fetched from memory as an aligned full word. It is written into its line and handed back in the same cycle the memory answers.

Stores always travel on to memory. A full-word store to a cacheable address also rewrites the tag and data of its line. A byte or halfword store instead marks the line invalid. An all-ones tag is the invalid marker, so no valid-bit array is kept. After reset, a sweep writes the marker into every line before the first request is accepted. Byte and halfword loads are cut out of the cached word according to a big-endian control input. Two saturating counters report cacheable load attempts and load misses.

Top module: `wt_word_cache`

## Requirements
- R1: After reset the block writes the invalid tag into every one of the 2048 lines, and holds `cpu_ready` low for at least 2048 cycles while it does so. The first load after the sweep misses.
- R2: An address is cacheable only when `(addr & 0xEFC00000) == 0`. Any other load or store is passed to memory with its own address and size. A bypassed load returns `mem_rdata` unaltered, changes no line and moves no counter.
- R3: A cacheable load whose line holds a matching valid tag completes with `cpu_ready` high in the same cycle the request is presented, and raises no memory request.
- R4: A cacheable load miss requests a word (`mem_size` = 2) at the address with bits [1:0] cleared, and keeps `mem_req` high until `mem_ack`. On `mem_ack` it returns the data and fills line `addr[12:2]` with tag `addr[21:13]`. Two addresses with the same index and different tags evict each other.
- R5: Tag value 0x1FF means invalid. An address whose bits [21:13] are all ones always misses, even after it has been filled or stored.
- R6: Every store raises `mem_req` with `mem_we` high and the store's own address, size and data. It completes on `mem_ack`.
- R7: A cacheable full-word store writes tag and data into its line. A later load of that word hits and returns the stored value.
- R8: A cacheable byte or halfword store invalidates its line, so the next load of that word misses.
- R9: Size encoding is 0 = byte, 1 = halfword, 2 = word. The lane number is `addr[1:0]`, XORed with 3 when `big_endian` is 1. A byte is taken from bits starting at 8 × lane and a halfword from bits starting at 16 × lane[1]. Results are zero-extended.
- R10: `stat_reads` counts every completed cacheable load and `stat_misses` counts those that missed. Both counters start at zero after reset and stop at all ones.
- R11: Address bit 28 lies outside both index and tag, so an address with bit 28 set hits the line filled through the same address with bit 28 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| big_endian | input | 1 | Selects big-endian lane numbering for sub-word loads |
| cpu_req | input | 1 | Processor request, held with its fields until `cpu_ready` |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | 32 | Load result, valid with `cpu_ready` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write |
| mem_size | output | 2 | Memory access size, same encoding as `cpu_size` |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle strobe ending the memory access |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| stat_reads | output | 32 | Saturating count of cacheable loads |
| stat_misses | output | 32 | Saturating count of cacheable load misses |

## Verification
The assertions assume that the processor holds `cpu_req` and all its fields steady from the cycle it raises the request until `cpu_ready`. They also assume that memory answers each request with one `mem_ack` pulse and no ack while `mem_req` is low. The bench keeps within this. It changes processor inputs only on falling edges after a completion, and its memory responder acks exactly two cycles into each request and returns a word computed from the aligned address. The stimulus sweeps 64 distinct index/tag pairs and every byte and halfword lane in both endian modes. It also drives the window edges, the reserved tag, aliasing on bit 28, and enough loads to saturate an 8-bit counter instance.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } xfer_size_e;

   typedef enum logic [1:0] {
      ST_INIT = 2'd0,
      ST_IDLE = 2'd1,
      ST_BUSY = 2'd2
   } ctl_state_e;

   localparam int STAT_COUNTERS = 2;
   localparam int STAT_LOADS    = 0;
   localparam int STAT_MISSES   = 1;

endpackage

// File: rtl/wtc_lane_extract.sv
module wtc_lane_extract
   import wtc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] word,
   input  logic [1:0]        addr_lo,
   input  logic [1:0]        size,
   input  logic              big_endian,
   output logic [DATA_W-1:0] result
);

   localparam int LANES  = DATA_W / 8;
   localparam int HALF_W = DATA_W / 2;

   if (DATA_W != 32) begin : g_bad_width
      $error("wtc_lane_extract: DATA_W must be 32");
   end

   logic [7:0]        byte_lane [LANES];
   logic [HALF_W-1:0] half_lane [2];
   logic [1:0]        lane;

   for (genvar g = 0; g < LANES; g++) begin : g_byte
      assign byte_lane[g] = word[g*8 +: 8];
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign half_lane[h] = word[h*HALF_W +: HALF_W];
   end

   assign lane = addr_lo ^ {2{big_endian}};

   always_comb begin
      case (size)
         SZ_BYTE: result = DATA_W'(byte_lane[lane]);
         SZ_HALF: result = DATA_W'(half_lane[lane[1]]);
         default: result = word;
      endcase
   end

endmodule

// File: rtl/wtc_sat_counter.sv
module wtc_sat_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);

   if (W < 2) begin : g_bad_width
      $error("wtc_sat_counter: W must be at least 2");
   end

   logic [W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (inc && (count_q != '1)) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign count = count_q;

   a_r10_stays_saturated: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == '1) |=> (count_q == '1));

   a_r10_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
   parameter int INDEX_W = 11,
   parameter int TAG_W   = 9,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic               init_busy,
   input  logic [INDEX_W-1:0] rd_idx,
   output logic [TAG_W-1:0]   rd_tag,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               wr_en,
   input  logic [INDEX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic               wr_data_en,
   input  logic [DATA_W-1:0]  wr_data
);

   localparam int LINES = 1 << INDEX_W;
   localparam logic [TAG_W-1:0] TAG_VOID = '1;

   if (INDEX_W < 1 || INDEX_W > 14) begin : g_bad_depth
      $error("wtc_line_store: INDEX_W out of range");
   end

   logic [TAG_W-1:0]   tag_mem  [LINES];
   logic [DATA_W-1:0]  data_mem [LINES];
   logic [INDEX_W-1:0] sweep_idx_q;
   logic               sweep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sweep_q     <= 1'b1;
         sweep_idx_q <= '0;
      end else if (sweep_q) begin
         sweep_idx_q <= sweep_idx_q + 1'b1;
         if (sweep_idx_q == '1) begin
            sweep_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (sweep_q) begin
         tag_mem[sweep_idx_q] <= TAG_VOID;
      end else if (wr_en) begin
         tag_mem[wr_idx] <= wr_tag;
         if (wr_data_en) begin
            data_mem[wr_idx] <= wr_data;
         end
      end
   end

   assign init_busy = sweep_q;
   assign rd_tag    = tag_mem[rd_idx];
   assign rd_data   = data_mem[rd_idx];

   a_r1_no_write_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_q |-> !wr_en);

   a_r1_sweep_never_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      !sweep_q |=> !sweep_q);

endmodule

// File: rtl/wt_word_cache.sv
module wt_word_cache
   import wtc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int INDEX_W = 11,
   parameter int TAG_W   = 9,
   parameter int CNT_W   = 32,
   parameter logic [ADDR_W-1:0] BYPASS_MASK = 32'hEFC0_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_endian,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [1:0]        mem_size,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [CNT_W-1:0]  stat_reads,
   output logic [CNT_W-1:0]  stat_misses
);

   localparam int TAG_LSB = INDEX_W + 2;
   localparam logic [TAG_W-1:0] TAG_VOID = '1;

   if (TAG_LSB + TAG_W > ADDR_W) begin : g_bad_tag
      $error("wt_word_cache: tag field exceeds address width");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("wt_word_cache: DATA_W must be 32");
   end

   ctl_state_e         state_q, state_d;
   logic               init_busy;
   logic [TAG_W-1:0]   line_tag;
   logic [DATA_W-1:0]  line_data;
   logic [INDEX_W-1:0] line_idx;
   logic [TAG_W-1:0]   addr_tag;
   logic               cacheable;
   logic               is_load;
   logic               is_word;
   logic               tag_hit;
   logic               fast_hit;
   logic               mem_done;
   logic               line_wr;
   logic               line_wr_data;
   logic [TAG_W-1:0]   line_wr_tag;
   logic [DATA_W-1:0]  line_wr_word;
   logic [DATA_W-1:0]  src_word;
   logic [DATA_W-1:0]  lane_word;
   logic [STAT_COUNTERS-1:0] cnt_inc;
   logic [CNT_W-1:0]   cnt_val [STAT_COUNTERS];

   // address decode
   assign cacheable = (cpu_addr & BYPASS_MASK) == '0;
   assign line_idx  = cpu_addr[TAG_LSB-1:2];
   assign addr_tag  = cpu_addr[TAG_LSB +: TAG_W];
   assign is_load   = !cpu_we;
   assign is_word   = (cpu_size == SZ_WORD);
   assign tag_hit   = (line_tag == addr_tag) && (line_tag != TAG_VOID);
   assign fast_hit  = (state_q == ST_IDLE) && cpu_req && cacheable && is_load && tag_hit;
   assign mem_done  = (state_q == ST_BUSY) && mem_ack;

   // control sequence
   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_INIT: if (!init_busy)             state_d = ST_IDLE;
         ST_IDLE: if (cpu_req && !fast_hit)   state_d = ST_BUSY;
         ST_BUSY: if (mem_ack)                state_d = ST_IDLE;
         default:                             state_d = ST_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_INIT;
      end else begin
         state_q <= state_d;
      end
   end

   // memory side, driven from the held processor request
   always_comb begin
      mem_req   = (state_q == ST_BUSY);
      mem_we    = cpu_we;
      mem_wdata = cpu_wdata;
      if (cacheable && is_load) begin
         mem_addr = {cpu_addr[ADDR_W-1:2], 2'b00};
         mem_size = SZ_WORD;
      end else begin
         mem_addr = cpu_addr;
         mem_size = cpu_size;
      end
   end

   // line update on memory completion
   always_comb begin
      line_wr      = mem_done && cacheable;
      line_wr_data = line_wr && (is_load || is_word);
      line_wr_tag  = (is_load || is_word) ? addr_tag : TAG_VOID;
      line_wr_word = cpu_we ? cpu_wdata : mem_rdata;
   end

   wtc_line_store #(
      .INDEX_W (INDEX_W),
      .TAG_W   (TAG_W),
      .DATA_W  (DATA_W)
   ) u_lines (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_busy  (init_busy),
      .rd_idx     (line_idx),
      .rd_tag     (line_tag),
      .rd_data    (line_data),
      .wr_en      (line_wr),
      .wr_idx     (line_idx),
      .wr_tag     (line_wr_tag),
      .wr_data_en (line_wr_data),
      .wr_data    (line_wr_word)
   );

   // load result
   assign src_word = (state_q == ST_BUSY) ? mem_rdata : line_data;

   wtc_lane_extract #(
      .DATA_W (DATA_W)
   ) u_lane (
      .word       (src_word),
      .addr_lo    (cpu_addr[1:0]),
      .size       (cpu_size),
      .big_endian (big_endian),
      .result     (lane_word)
   );

   assign cpu_ready = fast_hit || mem_done;
   assign cpu_rdata = cacheable ? lane_word : mem_rdata;

   // statistics
   assign cnt_inc[STAT_LOADS]  = cpu_ready && cacheable && is_load;
   assign cnt_inc[STAT_MISSES] = mem_done && cacheable && is_load;

   for (genvar k = 0; k < STAT_COUNTERS; k++) begin : g_stat
      wtc_sat_counter #(
         .W (CNT_W)
      ) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (cnt_inc[k]),
         .count (cnt_val[k])
      );
   end

   assign stat_reads  = cnt_val[STAT_LOADS];
   assign stat_misses = cnt_val[STAT_MISSES];

   // checks
   a_r1_silent_during_sweep: assert property (@(posedge clk) disable iff (!rst_n)
      init_busy |-> (!cpu_ready && !mem_req));

   a_r2_bypass_goes_to_memory: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_ready && !cacheable) |-> (mem_req && mem_ack));

   a_r3_hit_skips_memory: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !mem_req) |-> (cacheable && is_load));

   a_r4_fill_is_aligned_word: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && cacheable) |-> (mem_addr[1:0] == 2'b00 && mem_size == SZ_WORD));

   a_r4_req_held_to_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req);

   a_r5_void_tag_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !mem_req) |-> (line_tag != TAG_VOID));

   a_r6_store_written_through: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_ready && cpu_we) |-> (mem_req && mem_we && mem_ack));

   a_r10_misses_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      stat_misses <= stat_reads);

endmodule

// File: tb/wt_word_cache_tb_top.sv
module wt_word_cache_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LINES      = 2048;
   localparam int CNT_W      = 8;
   localparam int CNT_MAX    = 255;

   logic        clk;
   logic        rst_n;
   logic        big_endian;
   logic        cpu_req;
   logic        cpu_we;
   logic [1:0]  cpu_size;
   logic [31:0] cpu_addr;
   logic [31:0] cpu_wdata;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        mem_req;
   logic        mem_we;
   logic [1:0]  mem_size;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack;
   logic [31:0] mem_rdata;
   logic [CNT_W-1:0] stat_reads;
   logic [CNT_W-1:0] stat_misses;

   wt_word_cache #(.CNT_W(CNT_W)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .big_endian  (big_endian),
      .cpu_req     (cpu_req),
      .cpu_we      (cpu_we),
      .cpu_size    (cpu_size),
      .cpu_addr    (cpu_addr),
      .cpu_wdata   (cpu_wdata),
      .cpu_ready   (cpu_ready),
      .cpu_rdata   (cpu_rdata),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_size    (mem_size),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata),
      .stat_reads  (stat_reads),
      .stat_misses (stat_misses)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   int exp_reads = 0;
   int exp_miss  = 0;
   int last_cyc;
   bit last_mem;
   logic [31:0] last_rd;

   logic [31:0] wmem [logic [31:0]];
   logic [31:0] log_addr, log_wdata;
   logic [1:0]  log_size;
   logic        log_we;
   int          ack_wait;

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [31:0] k;
      k = {a[31:2], 2'b00};
      if (wmem.exists(k)) return wmem[k];
      return (k * 32'h9E37_79B1) ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [31:0] lane_ref(input logic [31:0] w, input logic [31:0] a,
                                            input logic [1:0] sz, input bit be);
      logic [1:0] ln;
      ln = a[1:0] ^ (be ? 2'b11 : 2'b00);
      if (sz == 2'd0) return (w >> (8 * ln)) & 32'hFF;
      if (sz == 2'd1) return (w >> (16 * ln[1])) & 32'hFFFF;
      return w;
   endfunction

   function automatic bit is_cacheable(input logic [31:0] a);
      return (a & 32'hEFC0_0000) == 32'h0;
   endfunction

   // memory responder: acks two cycles into each request
   initial begin
      mem_ack   = 1'b0;
      mem_rdata = '0;
      ack_wait  = 0;
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         if (mem_req) begin
            ack_wait++;
            if (ack_wait >= 2) begin
               mem_ack   = 1'b1;
               mem_rdata = mem_word(mem_addr);
               log_addr  = mem_addr;
               log_size  = mem_size;
               log_we    = mem_we;
               log_wdata = mem_wdata;
               if (mem_we && mem_size == 2'd2) wmem[{mem_addr[31:2], 2'b00}] = mem_wdata;
               ack_wait  = 0;
            end
         end else begin
            ack_wait = 0;
         end
      end
   end

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic access(input bit we, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] wd);
      @(negedge clk);
      cpu_req   = 1'b1;
      cpu_we    = we;
      cpu_size  = sz;
      cpu_addr  = a;
      cpu_wdata = wd;
      last_cyc  = 0;
      last_mem  = 1'b0;
      forever begin
         #1;
         if (mem_req) last_mem = 1'b1;
         if (cpu_ready) begin
            last_rd = cpu_rdata;
            @(posedge clk);
            #1;
            cpu_req = 1'b0;
            break;
         end
         @(negedge clk);
         last_cyc++;
      end
   endtask

   task automatic load(input logic [31:0] a, input logic [1:0] sz, input bit be,
                       input bit exp_hit, input logic [31:0] exp_data, input string rq);
      big_endian = be;
      access(1'b0, sz, a, 32'h0);
      check(last_rd == exp_data, rq, "load data", last_rd, exp_data);
      if (is_cacheable(a)) begin
         check(last_mem == !exp_hit, rq, "memory used on load", 32'(last_mem), 32'(!exp_hit));
         if (exp_reads < CNT_MAX) exp_reads++;
         if (!exp_hit && exp_miss < CNT_MAX) exp_miss++;
      end
   endtask

   task automatic store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d,
                        input string rq);
      access(1'b1, sz, a, d);
      check(last_mem && log_we, rq, "store reached memory", 32'(log_we), 32'h1);
      check(log_addr == a, rq, "store address", log_addr, a);
      check(log_size == sz, rq, "store size", 32'(log_size), 32'(sz));
      check(log_wdata == d, rq, "store data", log_wdata, d);
   endtask

   task automatic check_stats(input string rq);
      check(stat_reads == CNT_W'(exp_reads), rq, "load counter", 32'(stat_reads), 32'(exp_reads));
      check(stat_misses == CNT_W'(exp_miss), rq, "miss counter", 32'(stat_misses), 32'(exp_miss));
   endtask

   function automatic logic [31:0] sweep_addr(input int i);
      int tg, ix;
      tg = (i * 5 + 1) % 511;
      ix = (i * 37 + 3) % LINES;
      return (32'(tg) << 13) | (32'(ix) << 2);
   endfunction

   initial begin
      logic [31:0] a0, a1, a2, a_conf, a_void, a_lane;
      rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_size = 2'd2;
      cpu_addr = '0; cpu_wdata = '0; big_endian = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(!cpu_ready && !mem_req, "R1", "idle outputs in reset", 32'({cpu_ready, mem_req}), 32'h0);
      check_stats("R10");
      @(negedge clk);
      rst_n = 1'b1;

      // R1: first request waits out the sweep and misses
      load(32'h100, 2'd2, 1'b0, 1'b0, mem_word(32'h100), "R1");
      check(last_cyc >= LINES, "R1", "cycles before first completion", 32'(last_cyc), 32'(LINES));

      // R3 R4 R9: sweep over distinct lines
      for (int i = 0; i < 64; i++) begin
         logic [31:0] a;
         a = sweep_addr(i);
         load(a, 2'd2, 1'b0, 1'b0, mem_word(a), "R4");
         load(a, 2'd2, 1'b0, 1'b1, mem_word(a), "R3");
         check(last_cyc == 0, "R3", "hit latency", 32'(last_cyc), 32'h0);
         load(a | 32'(i % 4), 2'd0, bit'(i % 2), 1'b1,
              lane_ref(mem_word(a), a | 32'(i % 4), 2'd0, bit'(i % 2)), "R9");
      end
      check_stats("R10");

      // R4: conflict eviction on the same index
      a0     = sweep_addr(0);
      a1     = sweep_addr(1);
      a2     = sweep_addr(2);
      a_conf = a0 ^ 32'h0020_0000;
      load(a_conf, 2'd2, 1'b0, 1'b0, mem_word(a_conf), "R4");
      load(a0, 2'd2, 1'b0, 1'b0, mem_word(a0), "R4");

      // R11: bit 28 aliases onto the same line
      load(a0 | 32'h1000_0000, 2'd2, 1'b0, 1'b1, mem_word(a0), "R11");

      // R5: reserved tag always misses
      a_void = 32'h003F_FFFC;
      load(a_void, 2'd2, 1'b0, 1'b0, mem_word(a_void), "R5");
      load(a_void, 2'd2, 1'b0, 1'b0, mem_word(a_void), "R5");
      check_stats("R10");

      // R2: bypass window
      load(32'h2000_0012, 2'd1, 1'b0, 1'b0, mem_word(32'h2000_0010), "R2");
      check(last_mem, "R2", "bypass load used memory", 32'(last_mem), 32'h1);
      check(log_addr == 32'h2000_0012 && log_size == 2'd1, "R2", "bypass address/size",
            log_addr, 32'h2000_0012);
      load(32'h0040_0000, 2'd2, 1'b0, 1'b0, mem_word(32'h0040_0000), "R2");
      check(last_mem, "R2", "bit 22 bypasses", 32'(last_mem), 32'h1);
      store(32'h4000_0000 | a1, 2'd2, 32'hDEAD_BEEF, "R2");
      load(a1, 2'd2, 1'b0, 1'b1, mem_word(a1), "R2");
      check_stats("R2");

      // R6 R7: full-word store updates the line
      store(a2, 2'd2, 32'h0BAD_F00D, "R6");
      load(a2, 2'd2, 1'b0, 1'b1, 32'h0BAD_F00D, "R7");
      a_lane = 32'h0000_2000;
      store(a_lane, 2'd2, 32'hA1B2_C3D4, "R7");
      for (int be = 0; be < 2; be++) begin
         for (int off = 0; off < 4; off++) begin
            load(a_lane + 32'(off), 2'd0, bit'(be), 1'b1,
                 lane_ref(32'hA1B2_C3D4, a_lane + 32'(off), 2'd0, bit'(be)), "R9");
         end
         for (int off = 0; off < 4; off += 2) begin
            load(a_lane + 32'(off), 2'd1, bit'(be), 1'b1,
                 lane_ref(32'hA1B2_C3D4, a_lane + 32'(off), 2'd1, bit'(be)), "R9");
         end
      end

      // R8: sub-word stores invalidate
      store(a_lane + 32'h1, 2'd0, 32'h0000_0055, "R8");
      load(a_lane + 32'h2, 2'd0, 1'b1, 1'b0,
           lane_ref(mem_word(a_lane), a_lane + 32'h2, 2'd0, 1'b1), "R8");
      load(a_lane, 2'd2, 1'b0, 1'b1, mem_word(a_lane), "R8");
      store(a2 + 32'h2, 2'd1, 32'h0000_1234, "R8");
      load(a2, 2'd2, 1'b0, 1'b0, 32'h0BAD_F00D, "R8");

      // R5: a full store to the reserved tag still leaves it missing
      store(a_void, 2'd2, 32'h7777_0001, "R5");
      load(a_void, 2'd2, 1'b0, 1'b0, 32'h7777_0001, "R5");
      check_stats("R10");

      // R10: saturation
      for (int i = 0; i < 60; i++) begin
         load(a_lane, 2'd2, 1'b0, 1'b1, mem_word(a_lane), "R10");
      end
      check(stat_reads == CNT_W'(CNT_MAX), "R10", "load counter saturated",
            32'(stat_reads), 32'(CNT_MAX));
      check_stats("R10");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule